// File: doc/BRIEF.md
# Pattern-Indexed Waveform Memory

This block is the per-channel waveform store of a pattern-driven timing channel. Each clock an 8-bit pattern code arrives with a qualifying strobe. The code selects one of 256 waveform entries. Each entry holds four event slots, and each slot is a 22-bit delay plus a 4-bit event code. One clock later, the four slots of the selected entry are presented side by side to four downstream event generators. A cycle whose strobe is low produces no events: every slot output is held at zero and the output strobe is low.

In the same cycle, the pattern code is also split into pin-state bits and a time-set pointer. A per-cycle mode input sets how the split is done. Single-I/O mode gives one 3-bit pin state and a 5-bit time set. Dual-I/O mode gives two 3-bit pin states and a 2-bit time set.

A second, independent port lets a host processor read and write the store while patterns stream. The host port never stalls or delays the pattern path. The host sees the store as 1024 words of 26 bits. The upper eight address bits pick the entry and the lower two bits pick the slot.

Top module: `wave_lut_top`

## Requirements
- R1: While `rst` is high, `ev_valid` is low and `ev_delay`, `ev_code`, `pin_a`, `pin_b`, `tset` and `cpu_rdata` are all zero, whatever the other inputs are.
- R2: A host write with `cpu_we` high stores `cpu_wdata` into slot `cpu_addr[1:0]` of entry `cpu_addr[9:2]`. Within the word, bits [21:0] are the delay and bits [25:22] are the event code.
- R3: `cpu_rdata` shows, one clock after `cpu_addr` is presented, the word stored at that address. When a write to the same address happens in that cycle, it shows the value from before the write.
- R4: One clock after a cycle with `pat_valid` high and code P, `ev_valid` is high. For each slot k from 0 to 3, `ev_delay[22k+21:22k]` and `ev_code[4k+3:4k]` equal the delay and code of slot k of entry P.
- R5: One clock after a cycle with `pat_valid` low, `ev_valid` is low and `ev_delay`, `ev_code`, `pin_a`, `pin_b` and `tset` are all zero. `pat_data` and `io_dual` have no effect on that cycle.
- R6: When a host write and a pattern lookup touch the same entry in the same cycle, the lookup returns the entry as it was before the write. A lookup in the following cycle returns the new value.
- R7: With `io_dual` low, one clock after a valid cycle `pin_a` = P[2:0], `tset` = P[7:3] and `pin_b` = 0.
- R8: With `io_dual` high, one clock after a valid cycle `pin_a` = P[2:0], `pin_b` = P[5:3] and `tset` = P[7:6] zero-extended to 5 bits.
- R9: `io_dual` is sampled in the same cycle as the pattern code it applies to, so the mode may change from one cycle to the next.
- R10: Host reads and writes to any address never stall the pattern path. `ev_valid` follows `pat_valid` with one clock of latency in every cycle, whatever the host port does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_data | input | 8 | Pattern code; waveform pointer |
| pat_valid | input | 1 | Qualifies `pat_data` for this cycle |
| io_dual | input | 1 | 0 = single-I/O split, 1 = dual-I/O split |
| cpu_addr | input | 10 | Host word address: {entry, slot} |
| cpu_we | input | 1 | Host write enable |
| cpu_wdata | input | 26 | Host write word: {code[3:0], delay[21:0]} |
| cpu_rdata | output | 26 | Host read word, one clock after the address |
| ev_valid | output | 1 | Slot outputs carry events this cycle |
| ev_delay | output | 88 | Four 22-bit delays, slot 0 in the low bits |
| ev_code | output | 16 | Four 4-bit event codes, slot 0 in the low bits |
| pin_a | output | 3 | First pin-state field |
| pin_b | output | 3 | Second pin-state field (dual-I/O only) |
| tset | output | 5 | Time-set pointer |

## Verification
A slot bank that stored a word in the wrong place would show a wrong delay or code on that slot the next time its entry is looked up. It would also show a wrong `cpu_rdata` one clock after the host reads that address. A broken read-before-write order would show up in the collision cycle itself, as new data one clock early. Gating or split errors appear one clock after the offending input cycle, on `ev_valid`, the slot buses or the pin and time-set fields. The full read-back of all 1024 words and the dense random phase expose each of these within a few cycles.

// File: rtl/wlut_pkg.sv
package wlut_pkg;
    localparam int PAT_W   = 8;
    localparam int SLOTS   = 4;
    localparam int DLY_W   = 22;
    localparam int CODE_W  = 4;
    localparam int WORD_W  = DLY_W + CODE_W;
    localparam int PIN_W   = 3;
    localparam int TSET_W  = PAT_W - PIN_W;
    localparam int DTSET_W = PAT_W - 2 * PIN_W;

    typedef struct packed {
        logic [PIN_W-1:0]  pin_a;
        logic [PIN_W-1:0]  pin_b;
        logic [TSET_W-1:0] tset;
    } split_t;
endpackage

// File: rtl/wlut_bank.sv
module wlut_bank #(
    parameter int AW = 8,
    parameter int DW = 26
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] pa_addr,
    output logic [DW-1:0] pa_rdata,
    input  logic [AW-1:0] ca_addr,
    input  logic          ca_we,
    input  logic [DW-1:0] ca_wdata,
    output logic [DW-1:0] ca_rdata
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] pa;
        logic [DW-1:0] ca;
    } bank_regs_t;

    logic [DW-1:0] mem [DEPTH];
    bank_regs_t    r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.pa = mem[pa_addr];
        r_d.ca = mem[ca_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (ca_we) mem[ca_addr] <= ca_wdata;
    end

    assign pa_rdata = r_q.pa;
    assign ca_rdata = r_q.ca;

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R2 / R3: a written word reads back on the host port
    assert_write_readback_R2: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3 && $past(ca_we, 2) && !$past(ca_we) &&
         $past(ca_addr) == $past(ca_addr, 2))
        |-> ca_rdata == $past(ca_wdata, 2));

    // R6: a pattern read of an entry written in a cycle with no further write sees the new word two clocks on
    assert_collision_new_R6: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3 && $past(ca_we, 2) && !$past(ca_we) &&
         $past(pa_addr) == $past(ca_addr, 2))
        |-> pa_rdata == $past(ca_wdata, 2));
endmodule

// File: rtl/wlut_split.sv
module wlut_split
    import wlut_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PAT_W-1:0] pat_data,
    input  logic             pat_valid,
    input  logic             io_dual,
    output logic             valid_q,
    output split_t           fields_q
);
    typedef struct packed {
        logic   valid;
        split_t f;
    } split_regs_t;

    split_regs_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = pat_valid;
        s_d.f     = '0;
        if (pat_valid) begin
            s_d.f.pin_a = pat_data[PIN_W-1:0];
            if (io_dual) begin
                s_d.f.pin_b = pat_data[2*PIN_W-1:PIN_W];
                s_d.f.tset  = TSET_W'(pat_data[PAT_W-1:2*PIN_W]);
            end else begin
                s_d.f.tset  = pat_data[PAT_W-1:PIN_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign valid_q  = s_q.valid;
    assign fields_q = s_q.f;

    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    // R7: single-I/O leaves the second pin field empty
    assert_single_no_pinb_R7: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(pat_valid) && !$past(io_dual)) |-> fields_q.pin_b == '0);

    // R8: dual-I/O time set stays within four values
    assert_dual_tset_range_R8: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(pat_valid) && $past(io_dual)) |-> fields_q.tset < TSET_W'(1 << DTSET_W));

    // R5: an unqualified cycle yields empty fields
    assert_idle_fields_R5: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(pat_valid)) |-> (fields_q == '0 && !valid_q));
endmodule

// File: rtl/wave_lut_top.sv
module wave_lut_top
    import wlut_pkg::*;
#(
    parameter int PW   = PAT_W,
    parameter int NS   = SLOTS,
    parameter int DW   = DLY_W,
    parameter int CW   = CODE_W,
    parameter int PINW = PIN_W,
    parameter int TSW  = TSET_W,
    localparam int WW  = DW + CW,
    localparam int SAW = $clog2(NS),
    localparam int CAW = PW + SAW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    pat_data,
    input  logic             pat_valid,
    input  logic             io_dual,
    input  logic [CAW-1:0]   cpu_addr,
    input  logic             cpu_we,
    input  logic [WW-1:0]    cpu_wdata,
    output logic [WW-1:0]    cpu_rdata,
    output logic             ev_valid,
    output logic [NS*DW-1:0] ev_delay,
    output logic [NS*CW-1:0] ev_code,
    output logic [PINW-1:0]  pin_a,
    output logic [PINW-1:0]  pin_b,
    output logic [TSW-1:0]   tset
);
    typedef struct packed {
        logic [SAW-1:0] csel;
        logic           live;
    } top_regs_t;

    top_regs_t t_d, t_q;

    logic [WW-1:0] pa_word [NS];
    logic [WW-1:0] ca_word [NS];
    logic          valid_q;
    split_t        fields_q;

    wlut_split u_split (
        .clk      (clk),
        .rst      (rst),
        .pat_data (pat_data),
        .pat_valid(pat_valid),
        .io_dual  (io_dual),
        .valid_q  (valid_q),
        .fields_q (fields_q)
    );

    for (genvar k = 0; k < NS; k++) begin : g_slot
        logic bank_we;
        assign bank_we = cpu_we && (cpu_addr[SAW-1:0] == SAW'(k));

        wlut_bank #(.AW(PW), .DW(WW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .pa_addr (pat_data),
            .pa_rdata(pa_word[k]),
            .ca_addr (cpu_addr[CAW-1:SAW]),
            .ca_we   (bank_we),
            .ca_wdata(cpu_wdata),
            .ca_rdata(ca_word[k])
        );

        assign ev_delay[k*DW +: DW] = valid_q ? pa_word[k][DW-1:0]     : '0;
        assign ev_code [k*CW +: CW] = valid_q ? pa_word[k][WW-1:DW]    : '0;
    end

    always_comb begin
        t_d      = t_q;
        t_d.csel = cpu_addr[SAW-1:0];
        t_d.live = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign cpu_rdata = ca_word[t_q.csel];
    assign ev_valid  = valid_q;
    assign pin_a     = fields_q.pin_a;
    assign pin_b     = fields_q.pin_b;
    assign tset      = fields_q.tset;

    // R5: unqualified cycle suppresses every event
    assert_idle_no_events_R5: assert property (@(posedge clk) disable iff (rst)
        (t_q.live && !$past(pat_valid)) |-> (!ev_valid && ev_delay == '0 && ev_code == '0));

    // R10: host traffic never holds back a qualified lookup
    assert_no_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (t_q.live && $past(pat_valid)) |-> ev_valid);

    // R1: outputs quiet in the cycle after a reset cycle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!ev_valid && ev_code == '0 && cpu_rdata == '0));
endmodule

// File: tb/sim_wave_lut_top.sv
module sim_wave_lut_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   pat_data = '0;
    logic         pat_valid = 1'b0;
    logic         io_dual = 1'b0;
    logic [9:0]   cpu_addr = '0;
    logic         cpu_we = 1'b0;
    logic [25:0]  cpu_wdata = '0;
    logic [25:0]  cpu_rdata;
    logic         ev_valid;
    logic [87:0]  ev_delay;
    logic [15:0]  ev_code;
    logic [2:0]   pin_a, pin_b;
    logic [4:0]   tset;

    always #2 clk = ~clk;

    wave_lut_top u0 (
        .clk(clk), .rst(rst), .pat_data(pat_data), .pat_valid(pat_valid),
        .io_dual(io_dual), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ev_valid(ev_valid),
        .ev_delay(ev_delay), .ev_code(ev_code), .pin_a(pin_a), .pin_b(pin_b),
        .tset(tset)
    );

    logic [25:0] mdl [1024];
    int  n_vec = 0;
    int  n_bad = 0;
    bit  chk_rd = 1'b0;
    bit  done = 1'b0;

    task automatic chk(input string tag, input string what, input logic [87:0] act, input logic [87:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_pa(input logic v, input logic [7:0] p);
        return v ? p[2:0] : 3'd0;
    endfunction
    function automatic logic [2:0] exp_pb(input logic v, input logic d, input logic [7:0] p);
        return (v && d) ? p[5:3] : 3'd0;
    endfunction
    function automatic logic [4:0] exp_ts(input logic v, input logic d, input logic [7:0] p);
        if (!v) return 5'd0;
        return d ? {3'd0, p[7:6]} : p[7:3];
    endfunction

    // one clock: inputs already applied; sample 1 ns after the edge, then update model
    task automatic cyc(input string tev, input string tpin);
        string te, tp;
        @(posedge clk);
        #1;
        te = pat_valid ? tev : "R5";
        tp = !pat_valid ? "R5" : (tpin != "" ? tpin : (io_dual ? "R8" : "R7"));
        chk(cpu_we ? "R10" : te, "ev_valid", 88'(ev_valid), 88'(pat_valid));
        for (int k = 0; k < 4; k++) begin
            logic [25:0] w;
            w = pat_valid ? mdl[{pat_data, 2'(k)}] : 26'd0;
            chk(te, $sformatf("delay%0d", k), 88'(ev_delay[k*22 +: 22]), 88'(w[21:0]));
            chk(te, $sformatf("code%0d", k), 88'(ev_code[k*4 +: 4]), 88'(w[25:22]));
        end
        chk(tp, "pin_a", 88'(pin_a), 88'(exp_pa(pat_valid, pat_data)));
        chk(tp, "pin_b", 88'(pin_b), 88'(exp_pb(pat_valid, io_dual, pat_data)));
        chk(tp, "tset",  88'(tset),  88'(exp_ts(pat_valid, io_dual, pat_data)));
        if (chk_rd) chk("R3", "cpu_rdata", 88'(cpu_rdata), 88'(mdl[cpu_addr]));
        if (cpu_we) mdl[cpu_addr] = cpu_wdata;
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd4242);
        // R1: reset holds outputs low even with live inputs
        pat_valid = 1'b1; pat_data = 8'hFF; io_dual = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "ev_valid", 88'(ev_valid), 88'd0);
        chk("R1", "ev_code", 88'(ev_code), 88'd0);
        chk("R1", "ev_delay", ev_delay, 88'd0);
        chk("R1", "tset", 88'(tset), 88'd0);
        chk("R1", "cpu_rdata", 88'(cpu_rdata), 88'd0);
        rst = 1'b0; pat_valid = 1'b0;
        // fill the store (R2)
        for (int a = 0; a < 1024; a++) begin
            cpu_we = 1'b1; cpu_addr = 10'(a); cpu_wdata = 26'($urandom);
            @(posedge clk); #1;
            mdl[a] = cpu_wdata;
        end
        cpu_we = 1'b0;
        // R2: read-back of every word, checked one clock later
        for (int a = 0; a < 1024; a++) begin
            cpu_addr = 10'(a);
            @(posedge clk); #1;
            chk("R2", "readback", 88'(cpu_rdata), 88'(mdl[a]));
        end
        chk_rd = 1'b1;
        // R4: lookup of every entry in single mode
        for (int p = 0; p < 256; p++) begin
            pat_valid = 1'b1; pat_data = 8'(p); io_dual = 1'b0;
            cyc("R4", "");
        end
        // R6: collision returns old data, then new
        pat_valid = 1'b1; pat_data = 8'h5A; io_dual = 1'b0;
        cpu_we = 1'b1; cpu_addr = {8'h5A, 2'd1}; cpu_wdata = ~mdl[{8'h5A, 2'd1}];
        cyc("R6", "");
        cpu_we = 1'b0;
        cyc("R6", "");
        // R9: mode flips every cycle on the same code
        for (int i = 0; i < 8; i++) begin
            pat_valid = 1'b1; pat_data = 8'hB6; io_dual = i[0];
            cyc("R4", "R9");
        end
        // R5: unqualified cycles with busy inputs
        for (int i = 0; i < 4; i++) begin
            pat_valid = 1'b0; pat_data = 8'($urandom); io_dual = i[0];
            cyc("R5", "");
        end
        // random mix (R10 on host-write cycles)
        for (int i = 0; i < 3000; i++) begin
            pat_valid = ($urandom % 4) != 0;
            pat_data  = 8'($urandom);
            io_dual   = 1'($urandom);
            cpu_we    = 1'($urandom);
            cpu_addr  = ($urandom % 3 == 0) ? {pat_data, 2'($urandom)} : 10'($urandom);
            cpu_wdata = 26'($urandom);
            cyc("R4", "");
        end
        cpu_we = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule